// File: doc/BRIEF.md
# Repeat-Loop Program Counter Sequencer

This block owns the program counter of a simple in-order core and decides where it goes after each executed instruction word. Besides the ordinary one-word advance and taken branches, it runs a zero-overhead hardware repeat loop. A setup command gives the first and last word addresses of a code block and an iteration count. The sequencer then sends the PC back to the first word each time the last word completes, with no branch instruction in the loop body, until the count runs out.

The core pulses `step` once for each completed word. It also reports whether that word took a branch and, if so, where to. The sequencer presents the resulting address on `next_pc` during that cycle and registers it into `pc` at the clock edge. When the word just executed is the loop's last word, the loop check decides first; a branch or the plain advance applies only when the loop does not send the PC back. Fetch, decode and interrupts live elsewhere.

Top module: `rpt_pc_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc` loads `reset_vec`, `rpt_active` clears, and `rpt_count` becomes 0.
- R2: In a cycle with `step` low, `pc` keeps its value at the next edge and `next_pc` equals `pc`.
- R3: On a step with no taken branch and no loop redirect, the next PC is `pc + 1`, wrapping modulo 2^PC_W.
- R4: On a step with `br_taken` high and no loop redirect, the next PC is `br_target`.
- R5: On a step with `rpt_active` high, `pc` equal to the loop end address and `rpt_count` greater than 1, the count drops by one and the next PC is the loop start address, whatever `br_taken` says.
- R6: On a step with `rpt_active` high, `pc` equal to the loop end address and `rpt_count` equal to 1, the count becomes 0 and `rpt_active` clears. The PC is not redirected: it follows R3 or R4.
- R7: On a step with `rpt_active` high and `pc` different from the loop end address, `rpt_count` and `rpt_active` are unchanged.
- R8: `setup` loads the loop start, end and count from `setup_start`, `setup_end` and `setup_count`. `rpt_active` becomes 1 when the count is nonzero and 0 when it is zero. A setup alone does not move `pc`.
- R9: When `setup` and `step` are high in the same cycle, the PC update uses the loop state from before the setup, and the loop registers take the setup values instead of any decrement.
- R10: While `step` is high, `next_pc` shows, in that same cycle, the value that `pc` takes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reset_vec | input | PC_W | Address loaded into the PC on reset |
| step | input | 1 | One instruction word completed this cycle |
| br_taken | input | 1 | The completed word took a branch |
| br_target | input | PC_W | Branch destination word address |
| setup | input | 1 | Load loop registers this cycle |
| setup_start | input | PC_W | First word address of the loop block |
| setup_end | input | PC_W | Last word address of the loop block |
| setup_count | input | CNT_W | Number of passes through the block |
| next_pc | output | PC_W | PC after the current step (equals `pc` without a step) |
| pc | output | PC_W | Current program counter |
| rpt_active | output | 1 | Repeat loop armed |
| rpt_count | output | CNT_W | Remaining passes of the repeat loop |

## Verification
The bench runs a three-word loop through every pass and checks that it falls out to the following word only after the last pass. A design off by one in the count test would run one pass too many or too few. A one-word loop whose end word also takes a branch shows priority: a design that lets the branch win would leave the loop early, and one that redirects on the final pass would never fall through to the branch target. The bench also covers a zero-count setup sitting on its own end address, a step away from the end address, a setup in the same cycle as a redirecting step, and PC wrap at the top of the address space. Wrong handling of these would leave a phantom loop running, decrement on every word, lose either the old redirect or the new loop values, or corrupt the address on overflow.

// File: rtl/rpt_pc_seq.sv
`timescale 1ns/1ps
module rpt_pc_seq #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  reset_vec,
  input  logic             step,
  input  logic             br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic             setup,
  input  logic [PC_W-1:0]  setup_start,
  input  logic [PC_W-1:0]  setup_end,
  input  logic [CNT_W-1:0] setup_count,
  output logic [PC_W-1:0]  next_pc,
  output logic [PC_W-1:0]  pc,
  output logic             rpt_active,
  output logic [CNT_W-1:0] rpt_count
);

  logic [PC_W-1:0]  pc_q, start_q, end_q;
  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  logic             end_hit, loop_back;
  logic [CNT_W-1:0] cnt_dec;
  logic [PC_W-1:0]  seq_pc;

  assign end_hit   = act_q && (pc_q == end_q);
  assign cnt_dec   = cnt_q - CNT_W'(1);
  assign loop_back = end_hit && (cnt_dec != '0);
  assign seq_pc    = br_taken ? br_target : pc_q + PC_W'(1);
  assign next_pc   = !step ? pc_q : (loop_back ? start_q : seq_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= reset_vec;
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
    end else begin
      if (step) pc_q <= next_pc;
      if (setup) begin
        start_q <= setup_start;
        end_q   <= setup_end;
        cnt_q   <= setup_count;
        act_q   <= (setup_count != '0);
      end else if (step && end_hit) begin
        cnt_q <= cnt_dec;
        if (!loop_back) act_q <= 1'b0;
      end
    end
  end

  assign pc         = pc_q;
  assign rpt_active = act_q;
  assign rpt_count  = cnt_q;

  // R2
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc_q));

  // R3
  incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !act_q && !br_taken) |=> pc_q == $past(pc_q) + PC_W'(1));

  // R5
  loop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act_q && pc_q == end_q && cnt_q > CNT_W'(1)) |=> pc_q == $past(start_q));

  // R6
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act_q && pc_q == end_q && cnt_q == CNT_W'(1) && !setup) |=> (!act_q && cnt_q == '0));

  // R7
  off_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act_q && pc_q != end_q && !setup) |=> (act_q && $stable(cnt_q)));

  // R8
  zero_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (setup && setup_count == '0) |=> !act_q);

endmodule

// File: tb/sim_rpt_pc_seq.sv
`timescale 1ns/1ps
module sim_rpt_pc_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reset_vec = 16'h0100;
  logic        step = 1'b0, br_taken = 1'b0, setup = 1'b0;
  logic [15:0] br_target = '0, setup_start = '0, setup_end = '0, setup_count = '0;
  logic [15:0] next_pc, pc, rpt_count;
  logic        rpt_active;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rpt_pc_seq #(.PC_W(16), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .reset_vec(reset_vec), .step(step),
    .br_taken(br_taken), .br_target(br_target), .setup(setup),
    .setup_start(setup_start), .setup_end(setup_end), .setup_count(setup_count),
    .next_pc(next_pc), .pc(pc), .rpt_active(rpt_active), .rpt_count(rpt_count));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one word at negedge, check next_pc in-cycle and pc after the edge
  task automatic word(logic tk, logic [15:0] tgt, logic [15:0] exp, string req);
    step = 1'b1; br_taken = tk; br_target = tgt;
    #1 chk({req, " next_pc"}, next_pc, exp);
    @(negedge clk);
    step = 1'b0; br_taken = 1'b0;
    chk({req, " pc"}, pc, exp);
  endtask

  task automatic load(logic [15:0] s, logic [15:0] e, logic [15:0] c, logic with_step);
    setup = 1'b1; setup_start = s; setup_end = e; setup_count = c; step = with_step;
    @(negedge clk);
    setup = 1'b0; step = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 pc", pc, 16'h0100);
    chk("R1 active", rpt_active, 0);
    chk("R1 count", rpt_count, 0);
  endtask

  task automatic t_hold;
    br_taken = 1'b1; br_target = 16'h0ABC;
    #1 chk("R2 next_pc", next_pc, 16'h0100);
    repeat (3) @(negedge clk);
    br_taken = 1'b0;
    chk("R2 pc", pc, 16'h0100);
  endtask

  task automatic t_incr;
    word(0, 0, 16'h0101, "R3 R10");
    word(0, 0, 16'h0102, "R3");
  endtask

  task automatic t_branch;
    word(1, 16'h0200, 16'h0200, "R4");
  endtask

  task automatic t_loop3;
    load(16'h0200, 16'h0202, 16'd3, 0);
    chk("R8 pc", pc, 16'h0200);
    chk("R8 active", rpt_active, 1);
    chk("R8 count", rpt_count, 3);
    for (int p = 0; p < 3; p++) begin
      word(0, 0, 16'h0201, "R7");
      chk("R7 count", rpt_count, 3 - p);
      word(0, 0, 16'h0202, "R7");
      word(0, 0, (p == 2) ? 16'h0203 : 16'h0200, (p == 2) ? "R6" : "R5");
      chk("R5 R6 count", rpt_count, 2 - p);
    end
    chk("R6 active", rpt_active, 0);
  endtask

  task automatic t_prio;
    load(16'h0203, 16'h0203, 16'd2, 0);
    word(1, 16'h0500, 16'h0203, "R5 priority");
    chk("R5 count", rpt_count, 1);
    word(1, 16'h0500, 16'h0500, "R6 branch");
    chk("R6 active", rpt_active, 0);
  endtask

  task automatic t_zero;
    load(16'h0010, 16'h0500, 16'd0, 0);
    chk("R8 zero active", rpt_active, 0);
    word(0, 0, 16'h0501, "R8 zero");
    chk("R8 zero count", rpt_count, 0);
  endtask

  task automatic t_offend;
    load(16'h0010, 16'h0600, 16'd5, 0);
    word(0, 0, 16'h0502, "R7");
    chk("R7 count", rpt_count, 5);
    chk("R7 active", rpt_active, 1);
  endtask

  task automatic t_same_cycle;
    load(16'h0040, 16'h0502, 16'd2, 0);
    load(16'h0080, 16'h0900, 16'd7, 1);
    chk("R9 pc", pc, 16'h0040);
    chk("R9 count", rpt_count, 7);
    chk("R9 active", rpt_active, 1);
    word(0, 0, 16'h0041, "R9 new end");
  endtask

  task automatic t_wrap;
    word(1, 16'hFFFF, 16'hFFFF, "R4");
    word(0, 0, 16'h0000, "R3 wrap");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_hold();
        t_incr();
        t_branch();
        t_loop3();
        t_prio();
        t_zero();
        t_offend();
        t_same_cycle();
        t_wrap();
        done = 1;
      end
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          n_run++; n_fail++;
          $display("FAIL watchdog actual=timeout expected=finish");
        end
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule